// File: doc/BRIEF.md
# SD Single-Block Read Sequencer

This block performs one 512-byte block read from a memory card without software help. It is a master on a simple register bus in front of an SD/MMC host controller. A start pulse carrying the card block address makes it program the controller's transfer registers, issue the read-block command, and then poll the controller's status word. It advances only when the command response has arrived, then when the data block has ended with a good CRC, and then when the receive FIFO has drained.

The receive-overrun flag can be raised a couple of bus cycles after the data block ends. For that reason the sequencer reads it only from a fresh status read issued after the FIFO is seen empty. Each polling phase has a watchdog measured in clock cycles. Error bits reported by the controller abort the sequence at once. The outcome is a one-cycle done pulse, with ok or error and a 4-bit error code held until the next start.

Top module: `sd_blk_rd_seq`

## Requirements
- R1: After a start, exactly four register writes are issued, in this order: length at `LEN_OFS`, data control at `DCTL_OFS`, argument at `ARG_OFS`, command at `CMD_OFS`. A write request keeps its address, data and direction stable until `bus_ready_i` accepts it.
- R2: The length write carries `BLK_BYTES` (512). The data-control write carries 0x9B: bit0 transfer enable = 1, bit1 direction card-to-host = 1, bit2 stream mode = 0, bit3 DMA enable = 1, bits 7:4 block-size code = log2(512) = 9, and all other bits 0.
- R3: The argument write carries the `card_addr_i` captured with the start. The command write carries 0x451: bits 5:0 index = 17, bit6 wait-for-response = 1, bit10 command enable = 1, and all other bits 0.
- R4: Command phase. Status reads repeat until status bit6 (response received) is set. If bit0 (command CRC fail) is seen first, the sequence ends with code 1. If bit2 (command timeout) is seen first, it ends with code 2.
- R5: Data phase. After bit6 is seen, status reads repeat until bit10 (block end, CRC good) is set. Bit1 (data CRC fail) ends the sequence with code 3, and bit3 (data timeout) ends it with code 4.
- R6: After bit10 is seen, status reads repeat until bit19 (receive FIFO empty) is set. One further status read is then made. If its bit5 (receive overrun) is set, the code is 5; otherwise the code is 0. An overrun raised after block end but before the FIFO drains must be reported.
- R7: Each polling phase may last no more than `poll_limit_i` cycles. If it runs out, the sequence ends with code 6 (command phase), 7 (data phase) or 8 (FIFO/overrun phase).
- R8: A start pulse while `busy_o` is high is ignored. It has no effect on the written argument and does not cause a second run.
- R9: `done_o` is high for exactly one cycle at the end of each run. `ok_o` (code 0) and `err_o` (code nonzero) are never both high, hold until the next accepted start, and clear on that start.
- R10: After reset, `busy_o`, `done_o`, `ok_o`, `err_o` and `bus_req_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| card_addr_i | input | DW | Card block address, sampled with start |
| poll_limit_i | input | TO_W | Cycle limit for each polling phase |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| ok_o | output | 1 | Last run succeeded |
| err_o | output | 1 | Last run failed |
| err_code_o | output | 4 | Code of the last run (0 = none) |
| bus_req_o | output | 1 | Bus request valid |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | AW | Register offset |
| bus_wdata_o | output | DW | Write data |
| bus_ready_i | input | 1 | Request accepted this cycle |
| bus_rvalid_i | input | 1 | Read data valid (at least one cycle after accept) |
| bus_rdata_i | input | DW | Read data |

## Verification
The main corner case is an overrun that rises after block end but before the FIFO empties. A sequencer that samples bit5 at block end, or in the same read that first shows an empty FIFO, reports success where code 5 is expected. Each controller error bit and each phase watchdog is driven on its own. This exposes a design that checks error bits in the wrong phase, gives them the wrong priority, or tags a timeout with another phase's code. Bus stalls and a second start pulse during a run test write ordering and hold behaviour, and show whether the captured address can be overwritten or a second run started.

// File: rtl/sd_rd_pkg.sv
package sd_rd_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_WR_LEN, S_WR_DCTL, S_WR_ARG, S_WR_CMD, S_POLL_REQ, S_POLL_RSP
  } seq_state_e;

  typedef enum logic [1:0] {PH_CMD, PH_DAT, PH_FIFO, PH_OVR} phase_e;

  typedef enum logic [3:0] {
    E_NONE    = 4'd0,
    E_CMD_CRC = 4'd1,
    E_CMD_TO  = 4'd2,
    E_DAT_CRC = 4'd3,
    E_DAT_TO  = 4'd4,
    E_OVERRUN = 4'd5,
    E_WD_CMD  = 4'd6,
    E_WD_DAT  = 4'd7,
    E_WD_FIFO = 4'd8
  } err_e;

  // status word bit positions
  localparam int ST_CCRC   = 0;
  localparam int ST_DCRC   = 1;
  localparam int ST_CTO    = 2;
  localparam int ST_DTO    = 3;
  localparam int ST_OVR    = 5;
  localparam int ST_CREND  = 6;
  localparam int ST_DBEND  = 10;
  localparam int ST_FEMPTY = 19;

  localparam int CMD_IDX   = 17;

endpackage

// File: rtl/sd_rd_poll_timer.sv
module sd_rd_poll_timer #(
  parameter int TO_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic [TO_W-1:0] limit_i,
  output logic            expired_o
);
  localparam logic [TO_W-1:0] CNT_MAX = '1;

  logic [TO_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q >= limit_i);

  // once expired, stays expired until cleared (limit held)
  assert_expiry_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && expired_o) |=> (expired_o || !$stable(limit_i)));

endmodule

// File: rtl/sd_rd_classify.sv
module sd_rd_classify
  import sd_rd_pkg::*;
#(
  parameter int DW = 32
) (
  input  phase_e        phase_i,
  input  logic [DW-1:0] sta_i,
  output logic          adv_o,
  output logic          fail_o,
  output err_e          code_o
);
  logic unused_sta;
  assign unused_sta = ^sta_i;

  always_comb begin
    adv_o  = 1'b0;
    fail_o = 1'b0;
    code_o = E_NONE;
    unique case (phase_i)
      PH_CMD: begin
        if (sta_i[ST_CCRC])      begin fail_o = 1'b1; code_o = E_CMD_CRC; end
        else if (sta_i[ST_CTO])  begin fail_o = 1'b1; code_o = E_CMD_TO;  end
        else                     adv_o = sta_i[ST_CREND];
      end
      PH_DAT: begin
        if (sta_i[ST_DCRC])      begin fail_o = 1'b1; code_o = E_DAT_CRC; end
        else if (sta_i[ST_DTO])  begin fail_o = 1'b1; code_o = E_DAT_TO;  end
        else                     adv_o = sta_i[ST_DBEND];
      end
      PH_FIFO: adv_o = sta_i[ST_FEMPTY];
      PH_OVR: begin
        if (sta_i[ST_OVR])       begin fail_o = 1'b1; code_o = E_OVERRUN; end
        else                     adv_o = 1'b1;
      end
      default: ;
    endcase
  end

  assert_adv_fail_excl_R4: assert final (!(adv_o && fail_o));

endmodule

// File: rtl/sd_blk_rd_seq.sv
module sd_blk_rd_seq
  import sd_rd_pkg::*;
#(
  parameter int            AW        = 8,
  parameter int            DW        = 32,
  parameter int            TO_W      = 16,
  parameter int            BLK_BYTES = 512,
  parameter logic [AW-1:0] LEN_OFS   = 'h10,
  parameter logic [AW-1:0] DCTL_OFS  = 'h14,
  parameter logic [AW-1:0] ARG_OFS   = 'h04,
  parameter logic [AW-1:0] CMD_OFS   = 'h08,
  parameter logic [AW-1:0] STA_OFS   = 'h20
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [DW-1:0]   card_addr_i,
  input  logic [TO_W-1:0] poll_limit_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            ok_o,
  output logic            err_o,
  output logic [3:0]      err_code_o,
  output logic            bus_req_o,
  output logic            bus_we_o,
  output logic [AW-1:0]   bus_addr_o,
  output logic [DW-1:0]   bus_wdata_o,
  input  logic            bus_ready_i,
  input  logic            bus_rvalid_i,
  input  logic [DW-1:0]   bus_rdata_i
);
  localparam int            BLK_CODE  = $clog2(BLK_BYTES);
  localparam logic [DW-1:0] LEN_WORD  = DW'(BLK_BYTES);
  // enable | dir=rx | block mode | dma | size code
  localparam logic [DW-1:0] DCTL_WORD = DW'((BLK_CODE << 4) | 'h1 | 'h2 | 'h8);
  localparam logic [DW-1:0] CMD_WORD  = DW'(CMD_IDX | (1 << 6) | (1 << 10));

  seq_state_e    state_q;
  phase_e        phase_q;
  logic [DW-1:0] arg_q;
  logic          done_q, ok_q, err_q, fifo_seen_q;
  err_e          code_q;

  logic adv, fail, expired, rsp_fire, wd_hit, phase_chg, polling, tmr_clr;
  err_e cls_code, wd_code;

  sd_rd_classify #(.DW(DW)) u_cls (
    .phase_i (phase_q),
    .sta_i   (bus_rdata_i),
    .adv_o   (adv),
    .fail_o  (fail),
    .code_o  (cls_code)
  );

  sd_rd_poll_timer #(.TO_W(TO_W)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (tmr_clr),
    .limit_i   (poll_limit_i),
    .expired_o (expired)
  );

  assign polling   = (state_q == S_POLL_REQ) || (state_q == S_POLL_RSP);
  assign rsp_fire  = (state_q == S_POLL_RSP) && bus_rvalid_i;
  // a finishing response wins over the watchdog in the same cycle
  assign wd_hit    = polling && expired && !(rsp_fire && (adv || fail));
  assign phase_chg = rsp_fire && adv && !fail && (phase_q != PH_OVR);
  assign tmr_clr   = !polling || phase_chg;

  always_comb begin
    unique case (phase_q)
      PH_CMD:  wd_code = E_WD_CMD;
      PH_DAT:  wd_code = E_WD_DAT;
      default: wd_code = E_WD_FIFO;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      phase_q     <= PH_CMD;
      arg_q       <= '0;
      done_q      <= 1'b0;
      ok_q        <= 1'b0;
      err_q       <= 1'b0;
      code_q      <= E_NONE;
      fifo_seen_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          arg_q       <= card_addr_i;
          ok_q        <= 1'b0;
          err_q       <= 1'b0;
          code_q      <= E_NONE;
          phase_q     <= PH_CMD;
          fifo_seen_q <= 1'b0;
          state_q     <= S_WR_LEN;
        end
        S_WR_LEN:  if (bus_ready_i) state_q <= S_WR_DCTL;
        S_WR_DCTL: if (bus_ready_i) state_q <= S_WR_ARG;
        S_WR_ARG:  if (bus_ready_i) state_q <= S_WR_CMD;
        S_WR_CMD:  if (bus_ready_i) state_q <= S_POLL_REQ;
        S_POLL_REQ: begin
          if (wd_hit) begin
            state_q <= S_IDLE; done_q <= 1'b1; err_q <= 1'b1; code_q <= wd_code;
          end else if (bus_ready_i) begin
            state_q <= S_POLL_RSP;
          end
        end
        S_POLL_RSP: begin
          if (wd_hit) begin
            state_q <= S_IDLE; done_q <= 1'b1; err_q <= 1'b1; code_q <= wd_code;
          end else if (rsp_fire) begin
            if (fail) begin
              state_q <= S_IDLE; done_q <= 1'b1; err_q <= 1'b1; code_q <= cls_code;
            end else if (adv && phase_q == PH_OVR) begin
              state_q <= S_IDLE; done_q <= 1'b1; ok_q <= 1'b1; code_q <= E_NONE;
            end else begin
              if (adv) begin
                phase_q <= phase_e'(phase_q + 2'd1);
                if (phase_q == PH_FIFO) fifo_seen_q <= 1'b1;
              end
              state_q <= S_POLL_REQ;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_req_o   = 1'b1;
    bus_we_o    = 1'b1;
    bus_addr_o  = STA_OFS;
    bus_wdata_o = '0;
    unique case (state_q)
      S_WR_LEN:   begin bus_addr_o = LEN_OFS;  bus_wdata_o = LEN_WORD;  end
      S_WR_DCTL:  begin bus_addr_o = DCTL_OFS; bus_wdata_o = DCTL_WORD; end
      S_WR_ARG:   begin bus_addr_o = ARG_OFS;  bus_wdata_o = arg_q;     end
      S_WR_CMD:   begin bus_addr_o = CMD_OFS;  bus_wdata_o = CMD_WORD;  end
      S_POLL_REQ: bus_we_o = 1'b0;
      default:    begin bus_req_o = 1'b0; bus_we_o = 1'b0; end
    endcase
  end

  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = done_q;
  assign ok_o       = ok_q;
  assign err_o      = err_q;
  assign err_code_o = code_q;

  assert_wr_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_we_o && !bus_ready_i) |=>
      (bus_req_o && bus_we_o && $stable(bus_addr_o) && $stable(bus_wdata_o)));

  assert_ovr_after_fifo_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (ok_o || err_code_o == E_OVERRUN)) |-> fifo_seen_q);

  assert_arg_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && $past(busy_o)) |-> $stable(arg_q));

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_ok_err_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ok_o && err_o));

  assert_no_req_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !bus_req_o);

endmodule

// File: tb/sd_blk_rd_seq_bench.sv
module sd_blk_rd_seq_bench;
  localparam logic [7:0]  LEN_OFS = 8'h10, DCTL_OFS = 8'h14, ARG_OFS = 8'h04,
                          CMD_OFS = 8'h08;
  localparam logic [15:0] NV = 16'hFFFF;

  typedef struct packed {
    logic [15:0] t_cmd, t_dat, t_fifo, t_ovr, t_err;
    logic [3:0]  err_bits;  // maps to status bits 3:0
    logic [15:0] limit;
    logic        stall;
    logic [3:0]  exp;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{16'd5, 16'd20, 16'd30, NV,    NV,    4'h0, 16'd200, 1'b0, 4'd0}, // R6 clean
    '{16'd0, 16'd0,  16'd0,  NV,    NV,    4'h0, 16'd200, 1'b0, 4'd0}, // all ready at once
    '{16'd3, 16'd10, 16'd25, 16'd12, NV,   4'h0, 16'd200, 1'b0, 4'd5}, // R6 late overrun
    '{NV,    NV,     NV,     NV,    16'd4, 4'h1, 16'd200, 1'b0, 4'd1}, // R4 cmd crc
    '{NV,    NV,     NV,     NV,    16'd4, 4'h4, 16'd200, 1'b0, 4'd2}, // R4 cmd timeout
    '{16'd3, NV,     NV,     NV,    16'd8, 4'h2, 16'd200, 1'b0, 4'd3}, // R5 data crc
    '{16'd3, NV,     NV,     NV,    16'd8, 4'h8, 16'd200, 1'b0, 4'd4}, // R5 data timeout
    '{NV,    NV,     NV,     NV,    NV,    4'h0, 16'd30,  1'b0, 4'd6}, // R7 cmd wd
    '{16'd3, NV,     NV,     NV,    NV,    4'h0, 16'd30,  1'b0, 4'd7}, // R7 data wd
    '{16'd3, 16'd5,  NV,     NV,    NV,    4'h0, 16'd30,  1'b0, 4'd8}, // R7 fifo wd
    '{16'd6, 16'd14, 16'd40, NV,    NV,    4'h0, 16'd200, 1'b1, 4'd0}, // R1 stalled bus
    '{16'd2, 16'd6,  16'd6,  16'd6, NV,    4'h0, 16'd200, 1'b1, 4'd5}  // R6 overrun with end
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [31:0] card_addr_i = '0;
  logic [15:0] poll_limit_i = 16'd200;
  logic        busy_o, done_o, ok_o, err_o, bus_req_o, bus_we_o;
  logic [3:0]  err_code_o;
  logic [7:0]  bus_addr_o;
  logic [31:0] bus_wdata_o, bus_rdata_i;
  logic        bus_ready_i, bus_rvalid_i;

  int total = 0, bad = 0;

  always #10 clk_i = ~clk_i;

  sd_blk_rd_seq u_sd_blk_rd_seq (
    .clk_i, .rst_ni, .start_i, .card_addr_i, .poll_limit_i,
    .busy_o, .done_o, .ok_o, .err_o, .err_code_o,
    .bus_req_o, .bus_we_o, .bus_addr_o, .bus_wdata_o,
    .bus_ready_i, .bus_rvalid_i, .bus_rdata_i
  );

  // controller model
  vec_t        cur = '0;
  logic        log_clr = 1'b0;
  logic [7:0]  log_a [8];
  logic [31:0] log_d [8];
  int          log_n;
  logic [15:0] tcnt;
  int          cyc = 0;
  logic        ready_q = 1'b1, rvalid_q;
  logic [31:0] rdata_q;

  function automatic logic [31:0] sta_f(input vec_t v, input logic [15:0] t);
    logic [31:0] s = '0;
    s[6]  = (t >= v.t_cmd);
    s[10] = (t >= v.t_dat);
    s[19] = (t >= v.t_fifo);
    s[5]  = (t >= v.t_ovr);
    if (t >= v.t_err) s[3:0] = v.err_bits;
    return s;
  endfunction

  always @(negedge clk_i) begin
    cyc     <= cyc + 1;
    ready_q <= !cur.stall || (cyc % 3 != 0);
  end

  assign bus_ready_i  = ready_q;
  assign bus_rvalid_i = rvalid_q;
  assign bus_rdata_i  = rdata_q;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0; rdata_q <= '0; log_n <= 0; tcnt <= 16'hFFFE;
    end else begin
      rvalid_q <= 1'b0;
      if (log_clr) log_n <= 0;
      else if (bus_req_o && bus_we_o && bus_ready_i) begin
        if (log_n < 8) begin log_a[log_n] <= bus_addr_o; log_d[log_n] <= bus_wdata_o; end
        log_n <= log_n + 1;
      end
      if (bus_req_o && bus_we_o && bus_ready_i && bus_addr_o == CMD_OFS) tcnt <= 16'd0;
      else if (tcnt < 16'hFFFE) tcnt <= tcnt + 16'd1;
      if (bus_req_o && !bus_we_o && bus_ready_i) begin
        rvalid_q <= 1'b1;
        rdata_q  <= sta_f(cur, tcnt);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [31:0] a);
    @(negedge clk_i); start_i = 1'b1; card_addr_i = a; log_clr = 1'b1;
    @(negedge clk_i); start_i = 1'b0; log_clr = 1'b0;
  endtask

  task automatic wait_done(output int dn);
    int n = 0;
    while (!done_o && n < 3000) begin @(negedge clk_i); n++; end
    dn = done_o;
  endtask

  task automatic chk_writes(input logic [31:0] a);
    chk("R1 write count", log_n, 4);
    chk("R1 order len",  log_a[0], LEN_OFS);
    chk("R1 order dctl", log_a[1], DCTL_OFS);
    chk("R1 order arg",  log_a[2], ARG_OFS);
    chk("R1 order cmd",  log_a[3], CMD_OFS);
    chk("R2 length",     log_d[0], 32'd512);
    chk("R2 dctl word",  log_d[1], 32'h9B);
    chk("R3 argument",   log_d[2], a);
    chk("R3 cmd word",   log_d[3], 32'h451);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int dn;
    logic [31:0] a;
    repeat (3) @(negedge clk_i);
    chk("R10 busy",  busy_o, 0);
    chk("R10 done",  done_o, 0);
    chk("R10 ok",    ok_o, 0);
    chk("R10 err",   err_o, 0);
    chk("R10 req",   bus_req_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R10 idle after release", {busy_o, bus_req_o, ok_o, err_o}, 4'b0);

    for (int i = 0; i < NVEC; i++) begin
      cur = VECS[i];
      poll_limit_i = VECS[i].limit;
      a = 32'hA000_0000 + 32'(i) * 32'h200;
      pulse_start(a);
      chk("R9 ok cleared on start", ok_o | err_o, 0);
      wait_done(dn);
      chk("R9 done seen", dn, 1);
      chk(VECS[i].exp == 0 ? "R6 code" : (VECS[i].exp >= 6 ? "R7 code" :
          (VECS[i].exp <= 2 ? "R4 code" : (VECS[i].exp == 5 ? "R6 code" : "R5 code"))),
          err_code_o, VECS[i].exp);
      chk("R9 ok/err", {ok_o, err_o}, VECS[i].exp == 0 ? 2'b10 : 2'b01);
      chk_writes(a);
      @(negedge clk_i);
      chk("R9 done width", done_o, 0);
      repeat (5) @(negedge clk_i);
    end

    // R8: second start during a run is ignored
    cur = VECS[0];
    poll_limit_i = 16'd200;
    pulse_start(32'h1234_5600);
    @(negedge clk_i);
    start_i = 1'b1; card_addr_i = 32'hDEAD_0000;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_done(dn);
    chk("R8 run done", dn, 1);
    chk("R8 argument kept", log_d[2], 32'h1234_5600);
    chk("R8 writes", log_n, 4);
    begin
      int extra = 0;
      for (int k = 0; k < 100; k++) begin
        @(negedge clk_i);
        if (done_o || busy_o) extra++;
      end
      chk("R8 no second run", extra, 0);
    end
    chk("R9 ok held", {ok_o, err_o}, 2'b10);
    chk("R8 no extra writes", log_n, 4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule